// File: doc/BRIEF.md
# Switching Sequence Cost Selector

Each control period a modulator offers a small set of switching sequences that can all synthesize the same reference vector. The sequences differ only in how they load the two dc-link capacitors and in which gate pattern they start and end with. This block scores every offered sequence and returns the cheapest one. The score is the magnitude of the predicted imbalance between the two dc-link capacitor voltages, plus a weighted penalty for every gate that would toggle at the boundary between periods. The penalty is counted from the last gate pattern applied in the previous period to the candidate's opening pattern.

The caller presents, for each slot, a valid bit, the signed predicted imbalance, the 12-bit opening gate pattern and the 12-bit closing gate pattern. It then pulses `start`. Two cycles later `done` pulses with the winning slot index and its cost. At the same edge the winner's closing pattern becomes the stored history for the next period. The prediction of the capacitor voltages is done elsewhere.

Top module: `seq_cost_selector`

## Requirements
- R1: The toggle count of a slot is the number of bits that differ between the stored history pattern and that slot's opening pattern. Gate g (0..3) of phase p (0..2) sits at bit 4*p+g of each 12-bit pattern.
- R2: A slot's cost in `sel_cost` units is 2^FRAC·|imbalance| + WEIGHT·toggle count. With the defaults (FRAC=1, WEIGHT=1) one toggle weighs half an imbalance unit.
- R3: Among valid slots, the reported slot has the smallest cost, and `sel_cost` equals that cost.
- R4: When several valid slots share the minimum cost, the lowest slot index is reported.
- R5: A slot whose `cand_valid` bit is 0 is never reported, whatever its cost.
- R6: If no slot is valid, `done` still pulses with `sel_valid`=0, `sel_idx`=0 and `sel_cost`=0, and `prev_state` is unchanged.
- R7: After reset `prev_state` is all zeros. Each completion with `sel_valid`=1 loads it with the winner's closing pattern. It changes at no other time.
- R8: An accepted `start` yields a one-cycle `done` exactly two clock edges later. The result outputs hold their values until the next `done`.
- R9: A `start` that arrives in the cycle right after an accepted `start` is ignored and produces no second `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin evaluation of the presented slots |
| cand_valid | input | NUM_CAND | Per-slot valid mask |
| cand_imb | input | NUM_CAND*IMB_W | Signed predicted dc-link imbalance per slot, slot 0 in the low bits |
| cand_first | input | NUM_CAND*SW_W | Opening gate pattern per slot |
| cand_last | input | NUM_CAND*SW_W | Closing gate pattern per slot |
| done | output | 1 | One-cycle result strobe |
| sel_valid | output | 1 | At least one slot was valid |
| sel_idx | output | IDX_W | Winning slot index |
| sel_cost | output | COST_W | Winning cost |
| prev_state | output | SW_W | Stored closing pattern of the last applied sequence |

## Verification
A corrupted history register shows up one period later. Every toggle count is then wrong, so `sel_cost` drifts by WEIGHT per wrong bit, and the choice can flip to another slot. The bench tracks the expected history across a chain of periods and compares `prev_state` after each one. Faults in the comparison or in the masking show at the very `done` that follows. Such a fault appears as a wrong index on ties, as an invalid slot winning, or as a cost above another valid slot's cost. The directed cases target each of these faults.

// File: rtl/seqsel_pkg.sv
package seqsel_pkg;

   // Number of set bits in a vector of up to 64 bits.
   function automatic int unsigned seqsel_ones(input logic [63:0] v);
      int unsigned n;
      n = 0;
      for (int b = 0; b < 64; b++) n += int'(v[b]);
      return n;
   endfunction

   // Width able to hold an index into n entries (at least 1).
   function automatic int seqsel_idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/seqsel_toggle.sv
module seqsel_toggle #(
   parameter int SW_W  = 12,
   parameter int CNT_W = $clog2(SW_W + 1)
) (
   input  logic [SW_W-1:0]  hist,
   input  logic [SW_W-1:0]  first_pat,
   output logic [CNT_W-1:0] toggles
);
   import seqsel_pkg::*;

   if (SW_W > 64) begin : g_bad_width
      $error("seqsel_toggle: SW_W above 64 is not supported");
   end

   logic [63:0] diff;

   always_comb begin
      diff = '0;
      diff[SW_W-1:0] = hist ^ first_pat;
      toggles = CNT_W'(seqsel_ones(diff));
   end

endmodule

// File: rtl/seqsel_cost.sv
module seqsel_cost #(
   parameter int IMB_W  = 16,
   parameter int CNT_W  = 4,
   parameter int FRAC   = 1,
   parameter int WEIGHT = 1,
   parameter int COST_W = 26
) (
   input  logic signed [IMB_W-1:0] imb,
   input  logic [CNT_W-1:0]        toggles,
   output logic [COST_W-1:0]       cost
);
   logic [IMB_W-1:0] mag;

   always_comb begin
      mag  = imb[IMB_W-1] ? (IMB_W'(~imb) + IMB_W'(1)) : IMB_W'(imb);
      cost = (COST_W'(mag) << FRAC) + COST_W'(toggles) * COST_W'(WEIGHT);
   end

endmodule

// File: rtl/seqsel_argmin.sv
module seqsel_argmin #(
   parameter int N      = 5,
   parameter int COST_W = 26,
   parameter int IDX_W  = 3
) (
   input  logic [N-1:0]        vld,
   input  logic [N*COST_W-1:0] costs,
   output logic                any,
   output logic [IDX_W-1:0]    idx,
   output logic [COST_W-1:0]   min_cost
);
   // Linear scan upward: strict less-than keeps the lowest index on ties.
   always_comb begin
      any      = 1'b0;
      idx      = '0;
      min_cost = '0;
      for (int i = 0; i < N; i++) begin
         if (vld[i] && (!any || costs[i*COST_W +: COST_W] < min_cost)) begin
            any      = 1'b1;
            idx      = IDX_W'(i);
            min_cost = costs[i*COST_W +: COST_W];
         end
      end
   end

endmodule

// File: rtl/seq_cost_selector.sv
module seq_cost_selector #(
   parameter int NUM_CAND = 5,
   parameter int PHASES   = 3,
   parameter int GATES    = 4,
   parameter int IMB_W    = 16,
   parameter int FRAC     = 1,
   parameter int WEIGHT   = 1,
   parameter int WGT_W    = 4,
   parameter int SW_W     = PHASES * GATES,
   parameter int IDX_W    = seqsel_pkg::seqsel_idx_w(NUM_CAND),
   parameter int CNT_W    = $clog2(SW_W + 1),
   parameter int COST_W   = IMB_W + FRAC + CNT_W + WGT_W + 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [NUM_CAND-1:0]       cand_valid,
   input  logic [NUM_CAND*IMB_W-1:0] cand_imb,
   input  logic [NUM_CAND*SW_W-1:0]  cand_first,
   input  logic [NUM_CAND*SW_W-1:0]  cand_last,
   output logic                      done,
   output logic                      sel_valid,
   output logic [IDX_W-1:0]          sel_idx,
   output logic [COST_W-1:0]         sel_cost,
   output logic [SW_W-1:0]           prev_state
);
   if (NUM_CAND < 1) begin : g_bad_cand
      $error("seq_cost_selector: NUM_CAND must be at least 1");
   end
   if (WEIGHT < 0 || WEIGHT >= (1 << WGT_W)) begin : g_bad_weight
      $error("seq_cost_selector: WEIGHT must fit in WGT_W bits");
   end
   if (SW_W != PHASES * GATES) begin : g_bad_sw
      $error("seq_cost_selector: SW_W must equal PHASES*GATES");
   end

   // ---------------- stage 0: per-slot cost (combinational) ----------------
   logic [NUM_CAND*COST_W-1:0] cost_c;

   for (genvar c = 0; c < NUM_CAND; c++) begin : g_slot
      logic [CNT_W-1:0] tog;

      seqsel_toggle #(.SW_W(SW_W), .CNT_W(CNT_W)) i_toggle (
         .hist      (prev_state),
         .first_pat (cand_first[c*SW_W +: SW_W]),
         .toggles   (tog)
      );

      seqsel_cost #(
         .IMB_W(IMB_W), .CNT_W(CNT_W), .FRAC(FRAC),
         .WEIGHT(WEIGHT), .COST_W(COST_W)
      ) i_cost (
         .imb     (cand_imb[c*IMB_W +: IMB_W]),
         .toggles (tog),
         .cost    (cost_c[c*COST_W +: COST_W])
      );
   end

   // ---------------- stage 1: registered costs ----------------
   logic                       s1_vld;
   logic [NUM_CAND-1:0]        s1_mask;
   logic [NUM_CAND*COST_W-1:0] s1_cost;
   logic [NUM_CAND*SW_W-1:0]   s1_last;
   logic                       accept;

   assign accept = start && !s1_vld;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_vld  <= 1'b0;
         s1_mask <= '0;
         s1_cost <= '0;
         s1_last <= '0;
      end else begin
         s1_vld <= accept;
         if (accept) begin
            s1_mask <= cand_valid;
            s1_cost <= cost_c;
            s1_last <= cand_last;
         end
      end
   end

   // ---------------- stage 2: selection and history ----------------
   logic              win_any;
   logic [IDX_W-1:0]  win_idx;
   logic [COST_W-1:0] win_cost;

   seqsel_argmin #(.N(NUM_CAND), .COST_W(COST_W), .IDX_W(IDX_W)) i_argmin (
      .vld      (s1_mask),
      .costs    (s1_cost),
      .any      (win_any),
      .idx      (win_idx),
      .min_cost (win_cost)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done       <= 1'b0;
         sel_valid  <= 1'b0;
         sel_idx    <= '0;
         sel_cost   <= '0;
         prev_state <= '0;
      end else begin
         done <= s1_vld;
         if (s1_vld) begin
            sel_valid <= win_any;
            sel_idx   <= win_any ? win_idx : '0;
            sel_cost  <= win_any ? win_cost : '0;
            if (win_any) prev_state <= s1_last[win_idx*SW_W +: SW_W];
         end
      end
   end

   // ---------------- assertions ----------------
   for (genvar c = 0; c < NUM_CAND; c++) begin : g_chk
      assert_min_cost_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (s1_vld && s1_mask[c]) |=> (sel_valid && sel_cost <= $past(s1_cost[c*COST_W +: COST_W])));
      assert_tie_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (s1_vld && s1_mask[c]) |=>
            (sel_cost != $past(s1_cost[c*COST_W +: COST_W]) || sel_idx <= IDX_W'(c)));
      assert_masked_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (s1_vld && !s1_mask[c]) |=> (!sel_valid || sel_idx != IDX_W'(c)));
   end

   assert_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_vld && s1_mask == '0) |=> (!sel_valid && $stable(prev_state)));
   assert_hist_only_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(prev_state) |-> (done && sel_valid));
   assert_done_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      s1_vld |=> done);
   assert_done_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(s1_vld));
   assert_single_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: tb/test_seq_cost_selector.sv
module test_seq_cost_selector;
   localparam int NC = 5;
   localparam int IW = 16;
   localparam int SW = 12;
   localparam int XW = 3;
   localparam int CW = 26;
   localparam int NV = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [NC-1:0]    cand_valid = '0;
   logic [NC*IW-1:0] cand_imb = '0;
   logic [NC*SW-1:0] cand_first = '0;
   logic [NC*SW-1:0] cand_last = '0;
   logic done, sel_valid;
   logic [XW-1:0] sel_idx;
   logic [CW-1:0] sel_cost;
   logic [SW-1:0] prev_state;

   always #2.5 clk = ~clk;

   seq_cost_selector i_seq_cost_selector (
      .clk, .rst_n, .start, .cand_valid, .cand_imb, .cand_first, .cand_last,
      .done, .sel_valid, .sel_idx, .sel_cost, .prev_state
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // stimulus table: mask, imbalances, opening and closing patterns
   localparam logic [NC-1:0] TV_MASK [NV] = '{5'b11111, 5'b11111, 5'b10101, 5'b01110, 5'b11111, 5'b00001};
   localparam logic signed [IW-1:0] TV_IMB [NV][NC] = '{
      '{16'sd100, -16'sd40, 16'sd60, -16'sd40, 16'sd200},
      '{16'sd5, 16'sd5, 16'sd4, -16'sd6, 16'sd5},
      '{-16'sd32768, 16'sd0, 16'sd300, 16'sd1, 16'sd299},
      '{16'sd0, -16'sd7, 16'sd7, 16'sd3, 16'sd0},
      '{16'sd2, 16'sd1, 16'sd0, 16'sd1, 16'sd2},
      '{16'sd32767, 16'sd0, 16'sd0, 16'sd0, 16'sd0}};
   localparam logic [SW-1:0] TV_FIRST [NV][NC] = '{
      '{12'h000, 12'h00F, 12'hFFF, 12'h001, 12'h000},
      '{12'h111, 12'h333, 12'hFFF, 12'h0F0, 12'h123},
      '{12'hA5A, 12'h000, 12'h5A5, 12'hFFF, 12'h0C3},
      '{12'h0C3, 12'hF00, 12'h0C3, 12'h0C2, 12'h000},
      '{12'h000, 12'h0FF, 12'hFFF, 12'h0F0, 12'h00C},
      '{12'h3C3, 12'h000, 12'h000, 12'h000, 12'h000}};
   localparam logic [SW-1:0] TV_LAST [NV][NC] = '{
      '{12'h111, 12'h222, 12'h333, 12'h444, 12'h555},
      '{12'h0C3, 12'h00F, 12'h0F0, 12'hF00, 12'h321},
      '{12'h0F0, 12'hAAA, 12'h555, 12'h00C, 12'hC00},
      '{12'h00F, 12'h0FF, 12'hFF0, 12'h0F0, 12'h123},
      '{12'h800, 12'h001, 12'h3C3, 12'hFFF, 12'h0A0},
      '{12'h7E7, 12'h000, 12'h000, 12'h000, 12'h000}};

   logic [NC-1:0] m;
   logic signed [IW-1:0] im [NC];
   logic [SW-1:0] fs [NC];
   logic [SW-1:0] ls [NC];
   logic [SW-1:0] exp_hist = '0;
   int  e_idx, e_cost;
   bit  e_any;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Independent reference: cost = 2*|imb| + 1*differing bits, first strict minimum
   task automatic model();
      e_any = 0; e_idx = 0; e_cost = 0;
      for (int c = 0; c < NC; c++) begin
         int mag, cst;
         mag = int'(im[c]);
         if (mag < 0) mag = -mag;
         cst = 2 * mag + $countones(fs[c] ^ exp_hist);
         if (m[c] && (!e_any || cst < e_cost)) begin
            e_any = 1; e_idx = c; e_cost = cst;
         end
      end
   endtask

   task automatic drive();
      cand_valid = m;
      for (int c = 0; c < NC; c++) begin
         cand_imb[c*IW +: IW]   = im[c];
         cand_first[c*SW +: SW] = fs[c];
         cand_last[c*SW +: SW]  = ls[c];
      end
   endtask

   // one evaluation; checks latency, then result against the model
   task automatic run_eval(input string req);
      model();
      @(negedge clk);
      drive();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R8", "done one edge after start", done, 0);
      @(negedge clk);
      chk("R8", "done two edges after start", done, 1);
      chk(req, "sel_valid", sel_valid, e_any);
      chk(req, "sel_idx", sel_idx, e_any ? e_idx : 0);
      chk(req, "sel_cost", sel_cost, e_any ? e_cost : 0);
      if (e_any) exp_hist = ls[e_idx];
      chk("R7", "prev_state after done", prev_state, exp_hist);
      @(negedge clk);
      chk("R8", "done drops", done, 0);
      chk("R8", "sel_idx held", sel_idx, e_any ? e_idx : 0);
   endtask

   task automatic clear_slots();
      m = '0;
      for (int c = 0; c < NC; c++) begin
         im[c] = '0; fs[c] = '0; ls[c] = '0;
      end
   endtask

   initial begin
      clear_slots();
      repeat (3) @(negedge clk);
      chk("R7", "prev_state at reset", prev_state, 0);
      chk("R8", "done at reset", done, 0);
      chk("R6", "sel_valid at reset", sel_valid, 0);
      rst_n = 1'b1;

      // table walk: R1, R2, R3 over a chain of periods with evolving history
      for (int v = 0; v < NV; v++) begin
         m = TV_MASK[v];
         for (int c = 0; c < NC; c++) begin
            im[c] = TV_IMB[v][c]; fs[c] = TV_FIRST[v][c]; ls[c] = TV_LAST[v][c];
         end
         run_eval("R3");
      end

      // R1/R2: toggles outweigh imbalance; explicit expected values
      clear_slots();
      m = 5'b00011;
      im[0] = 16'sd0; fs[0] = exp_hist ^ 12'h007;  ls[0] = 12'h111;
      im[1] = 16'sd1; fs[1] = exp_hist;            ls[1] = 12'h222;
      run_eval("R2");
      chk("R1", "zero-toggle slot wins with cost 2", sel_cost, 2);
      chk("R2", "index of zero-toggle slot", sel_idx, 1);

      // R1: one toggle per phase at gate 3 (bits 3,7,11)
      clear_slots();
      m = 5'b00001; fs[0] = exp_hist ^ 12'h888; ls[0] = 12'h456;
      run_eval("R1");
      chk("R1", "three toggles cost", sel_cost, 3);

      // R4: all equal costs -> lowest index; then lowest valid index
      clear_slots();
      m = 5'b11111;
      for (int c = 0; c < NC; c++) begin
         im[c] = 16'sd10; fs[c] = exp_hist; ls[c] = SW'(c + 1);
      end
      run_eval("R4");
      chk("R4", "tie goes to slot 0", sel_idx, 0);
      m = 5'b11010;
      for (int c = 0; c < NC; c++) fs[c] = exp_hist;
      run_eval("R4");
      chk("R4", "tie goes to slot 1", sel_idx, 1);

      // R5: cheapest slot masked off
      clear_slots();
      m = 5'b11110;
      im[0] = 16'sd0; fs[0] = exp_hist; ls[0] = 12'hEEE;
      for (int c = 1; c < NC; c++) begin
         im[c] = 16'sd50; fs[c] = exp_hist; ls[c] = 12'h0A0;
      end
      im[3] = 16'sd20;
      run_eval("R5");
      chk("R5", "masked slot 0 not chosen", sel_idx, 3);
      chk("R5", "history not from masked slot", prev_state, 12'h0A0);

      // R6: empty mask leaves history unchanged
      clear_slots();
      m = 5'b00000; ls[0] = 12'hFFF; ls[4] = 12'h5A5;
      run_eval("R6");
      chk("R6", "history kept", prev_state, 12'h0A0);

      // R9: start held two cycles -> exactly one done
      begin
         int ndone;
         ndone = 0;
         clear_slots();
         m = 5'b00100; ls[2] = 12'h3F0; fs[2] = exp_hist;
         drive();
         @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         @(negedge clk);
         start = 1'b0;
         if (done) ndone++;
         for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (done) ndone++;
         end
         chk("R9", "done count for back-to-back start", ndone, 1);
         chk("R9", "result of accepted start", sel_idx, 2);
      end

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule